// File: doc/BRIEF.md
# Frame Sync Protection Controller

This block decides whether a recovered 2.048 Mbit/s serial stream is aligned to its 2048-bit frames. An upstream correlator flags each bit at which the frame sync word was found. The controller runs a flywheel position counter over those flags. A run of hits at the expected frame spacing acquires lock. A run of missing hits at the expected position while locked drops it. The number of misses needed to drop lock is set in software. The number of hits needed to gain lock is fixed.

A second flywheel of the same kind runs one level up, at the master frame. It advances once per locked frame and samples a master-frame marker, which is taken from one control-word bit and qualified at the frame's expected position. It has its own acquisition count and its own set of loss counts, and these are picked by the same 2-bit protection code. The block drives three outputs. The asynchronous flag is high while the frame is unlocked. A one-cycle frame-start strobe marks each expected frame position. A master-frame lock flag reports the state of the second flywheel.

Top module: `frame_sync_guard`

## Requirements
- R1: While `rst` is high and after its release (before any hit), `async_flag` is 1, `frame_start` is 0 and `mf_lock` is 0.
- R2: From the unlocked state, frame lock is gained at the third `sync_hit` in a chain whose hits are exactly FRAME_BITS qualified bits apart. `async_flag` falls in the cycle after the bit that carries the third hit, and before that bit it stays 1.
- R3: During acquisition, a missing hit at the expected position restarts the search, so a fresh chain of three hits is needed. A hit at any other position is ignored, both during acquisition and while locked.
- R4: While locked, lock is lost after consecutive missing hits at the expected position. The number needed is set by `front_sel`: 2'b11 gives 3, 2'b10 gives 5, 2'b01 gives 7 and 2'b00 gives 9. `async_flag` rises in the cycle after the bit that carries the final miss.
- R5: While locked, a hit at the expected position clears the running miss count.
- R6: `frame_start` is a one-cycle pulse in the cycle after each expected-position bit that is processed while locked. This includes the bit at which lock is gained and the bit at which lock is lost. Pulses are FRAME_BITS qualified bits apart.
- R7: `front_sel` is sampled at each expected frame position and when a search starts. A sampled value first governs the loss decision at the following expected position.
- R8: Cycles with `bit_en` low change nothing. The spacing of frames and master frames is counted in qualified bits only, and `sync_hit` and `mf_hit` are ignored in those cycles.
- R9: With `mf_enable` high and the frame locked, `mf_hit` is sampled once per frame, at the expected-position bit. `mf_lock` rises after the second marker in a chain whose markers are exactly MF_FRAMES frames apart. A marker in any other frame is ignored.
- R10: While master-frame locked, `mf_lock` falls after consecutive missing markers at the expected master position. The number needed is set by `front_sel`: 2'b11 gives 7, 2'b10 gives 9, and 2'b01 or 2'b00 gives 11.
- R11: Driving `mf_enable` low, or losing frame lock, clears `mf_lock` by the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies one received bit in this cycle |
| sync_hit | input | 1 | Correlator found the frame sync word at this bit |
| mf_hit | input | 1 | Master-frame marker for the current frame |
| mf_enable | input | 1 | Enables master-frame tracking |
| front_sel | input | 2 | Protection code selecting the loss counts |
| async_flag | output | 1 | High while frame alignment is not held |
| frame_start | output | 1 | One-cycle strobe at each locked frame position |
| mf_lock | output | 1 | High while master-frame alignment is held |

## Verification
Most internal faults surface first on `frame_start`. If the position counter slips, the strobe lands off the FRAME_BITS grid within one frame. If the hit or miss counter is wrong, `async_flag` moves by whole frames: lock comes a frame early or late, or is lost after the wrong number of misses. Faults in the protection code latch show up only as a one-frame shift in the loss point right after a code change. Faults in the master-frame path appear on `mf_lock` with a latency of whole master frames, which is why the bench shrinks both periods.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

  localparam int CNT_W = 4;

  // loss count of the frame flywheel for a protection code
  function automatic logic [CNT_W-1:0] frame_loss_count(input logic [1:0] code);
    case (code)
      2'b11:   return CNT_W'(3);
      2'b10:   return CNT_W'(5);
      2'b01:   return CNT_W'(7);
      default: return CNT_W'(9);
    endcase
  endfunction

  // loss count of the master-frame flywheel for a protection code
  function automatic logic [CNT_W-1:0] master_loss_count(input logic [1:0] code);
    case (code)
      2'b11:   return CNT_W'(7);
      2'b10:   return CNT_W'(9);
      default: return CNT_W'(11);
    endcase
  endfunction

endpackage

// File: rtl/fsp_front_cfg.sv
module fsp_front_cfg
  import fsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [1:0]       code_in,
  output logic [CNT_W-1:0] frame_limit,
  output logic [CNT_W-1:0] master_limit
);

  logic [1:0] code_q;

  // sampled only at frame boundaries so mid-frame writes never split a decision
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= 2'b00;
    end else if (load) begin
      code_q <= code_in;
    end
  end

  assign frame_limit  = frame_loss_count(code_q);
  assign master_limit = master_loss_count(code_q);

endmodule

// File: rtl/fsp_flywheel.sv
module fsp_flywheel
  import fsp_pkg::*;
#(
  parameter int PERIOD = 2048,
  parameter int REAR   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             hit,
  input  logic [CNT_W-1:0] front_lim,
  output logic             mark,
  output logic             lock_next,
  output sync_state_e      state_q
);

  localparam int POS_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] REAR_CNT = CNT_W'(REAR);

  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  sync_state_e      state_d;
  logic             at_pos0;

  assign at_pos0 = (pos_q == '0);
  assign pos_inc = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  assign cnt_inc = cnt_q + 1'b1;
  assign mark    = tick && at_pos0 && (state_q != ST_SEARCH);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    cnt_d   = cnt_q;
    if (tick) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (hit) begin
            state_d = ST_VERIFY;
            pos_d   = POS_W'(1);
            cnt_d   = CNT_W'(1);
          end
        end
        ST_VERIFY: begin
          pos_d = pos_inc;
          if (at_pos0) begin
            if (hit) begin
              if (cnt_inc >= REAR_CNT) begin
                state_d = ST_LOCKED;
                cnt_d   = '0;
              end else begin
                cnt_d = cnt_inc;
              end
            end else begin
              state_d = ST_SEARCH;
              pos_d   = '0;
              cnt_d   = '0;
            end
          end
        end
        ST_LOCKED: begin
          pos_d = pos_inc;
          if (at_pos0) begin
            if (hit) begin
              cnt_d = '0;
            end else if (cnt_inc >= front_lim) begin
              state_d = ST_SEARCH;
              pos_d   = '0;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        default: begin
          state_d = ST_SEARCH;
          pos_d   = '0;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign lock_next = !clr && (state_d == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: lock is never reached straight from search
  a_r3_no_direct_lock: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEARCH) |=> (state_q != ST_LOCKED));

  // R2: entering lock needs a qualified hit in the previous cycle
  a_r2_lock_on_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_LOCKED) |-> $past(tick && hit));

  // R8: no qualified bit, no change
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> ($stable(state_q) && $stable(pos_q) && $stable(cnt_q)));

  // R5: an expected hit while locked keeps lock with a cleared miss count
  a_r5_hit_clears: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && tick && at_pos0 && hit && !clr)
      |=> (state_q == ST_LOCKED && cnt_q == '0));

endmodule

// File: rtl/frame_sync_guard.sv
module frame_sync_guard
  import fsp_pkg::*;
#(
  parameter int FRAME_BITS = 2048,
  parameter int MF_FRAMES  = 16,
  parameter int FR_REAR    = 3,
  parameter int MF_REAR    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       sync_hit,
  input  logic       mf_hit,
  input  logic       mf_enable,
  input  logic [1:0] front_sel,
  output logic       async_flag,
  output logic       frame_start,
  output logic       mf_lock
);

  sync_state_e      fr_state, mf_state;
  logic             fr_mark, fr_lock_next;
  logic             mf_mark, mf_lock_next;
  logic [CNT_W-1:0] fr_limit, mf_limit;
  logic             code_load, mf_tick, mf_clr;
  logic             start_q;

  assign code_load = fr_mark || (bit_en && sync_hit && fr_state == ST_SEARCH);

  fsp_front_cfg u_cfg (
    .clk          (clk),
    .rst          (rst),
    .load         (code_load),
    .code_in      (front_sel),
    .frame_limit  (fr_limit),
    .master_limit (mf_limit)
  );

  fsp_flywheel #(
    .PERIOD (FRAME_BITS),
    .REAR   (FR_REAR)
  ) u_frame_fw (
    .clk       (clk),
    .rst       (rst),
    .clr       (1'b0),
    .tick      (bit_en),
    .hit       (sync_hit),
    .front_lim (fr_limit),
    .mark      (fr_mark),
    .lock_next (fr_lock_next),
    .state_q   (fr_state)
  );

  // master path advances one step per locked frame
  assign mf_tick = fr_mark && (fr_state == ST_LOCKED);
  assign mf_clr  = !mf_enable || (fr_state != ST_LOCKED);

  fsp_flywheel #(
    .PERIOD (MF_FRAMES),
    .REAR   (MF_REAR)
  ) u_master_fw (
    .clk       (clk),
    .rst       (rst),
    .clr       (mf_clr),
    .tick      (mf_tick),
    .hit       (mf_hit),
    .front_lim (mf_limit),
    .mark      (mf_mark),
    .lock_next (mf_lock_next),
    .state_q   (mf_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
    end else begin
      start_q <= fr_mark && ((fr_state == ST_LOCKED) || fr_lock_next);
    end
  end

  assign frame_start = start_q;
  assign async_flag  = (fr_state != ST_LOCKED);
  assign mf_lock     = (mf_state == ST_LOCKED);

  // R6: a strobe only appears next to a locked cycle
  a_r6_start_near_lock: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!async_flag || $past(!async_flag)));

  // R11: master lock requires frame lock and enable one cycle earlier
  a_r11_mf_needs_frame: assert property (@(posedge clk) disable iff (rst)
    mf_lock |-> $past(!async_flag && mf_enable));

endmodule

// File: tb/frame_sync_guard_tb.sv
`timescale 1ns/1ps
module frame_sync_guard_tb;

  localparam int FB = 64;
  localparam int MF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       sync_hit = 1'b0;
  logic       mf_hit = 1'b0;
  logic       mf_enable = 1'b0;
  logic [1:0] front_sel = 2'b11;
  logic       async_flag, frame_start, mf_lock;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  frame_sync_guard #(
    .FRAME_BITS (FB),
    .MF_FRAMES  (MF)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .sync_hit    (sync_hit),
    .mf_hit      (mf_hit),
    .mf_enable   (mf_enable),
    .front_sel   (front_sel),
    .async_flag  (async_flag),
    .frame_start (frame_start),
    .mf_lock     (mf_lock)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic h, input logic m);
    @(negedge clk);
    bit_en = 1'b1; sync_hit = h; mf_hit = m;
    @(posedge clk); #1;
    bit_en = 1'b0; sync_hit = 1'b0; mf_hit = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0; sync_hit = 1'b1; mf_hit = 1'b1;
      @(posedge clk); #1;
      sync_hit = 1'b0; mf_hit = 1'b0;
    end
  endtask

  // one frame from just after a mark to the next mark
  task automatic frame(input logic h, input logic m);
    idle(FB - 1);
    send(h, m);
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst = 1'b1; mf_enable = 1'b0; front_sel = code;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic acquire(input logic [1:0] code);
    do_reset(code);
    idle(7);
    send(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
  endtask

  task automatic t_r1_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 async in reset", async_flag, 1'b1);
    chk("R1 start in reset", frame_start, 1'b0);
    chk("R1 mf in reset", mf_lock, 1'b0);
    do_reset(2'b11);
    idle(100);
    chk("R1 async idle", async_flag, 1'b1);
    chk("R1 start idle", frame_start, 1'b0);
    chk("R1 mf idle", mf_lock, 1'b0);
  endtask

  task automatic t_r2_acquire();
    do_reset(2'b11);
    idle(5);
    send(1'b1, 1'b0);
    chk("R2 after hit1", async_flag, 1'b1);
    frame(1'b1, 1'b0);
    chk("R2 after hit2", async_flag, 1'b1);
    chk("R6 no strobe before lock", frame_start, 1'b0);
    frame(1'b1, 1'b0);
    chk("R2 lock at hit3", async_flag, 1'b0);
    chk("R6 strobe at lock", frame_start, 1'b1);
    send(1'b0, 1'b0);
    chk("R6 strobe one cycle", frame_start, 1'b0);
    idle(FB - 2);
    chk("R6 no strobe mid frame", frame_start, 1'b0);
    send(1'b1, 1'b0);
    chk("R6 strobe next frame", frame_start, 1'b1);
  endtask

  task automatic t_r3_restart();
    do_reset(2'b11);
    send(1'b1, 1'b0);
    idle(10);
    send(1'b1, 1'b0);   // off-position hit during acquisition
    idle(FB - 12);
    send(1'b1, 1'b0);
    chk("R3 two hits", async_flag, 1'b1);
    frame(1'b0, 1'b0);  // miss at expected position
    chk("R3 miss keeps unlocked", async_flag, 1'b1);
    frame(1'b1, 1'b0);
    chk("R3 restarted chain", async_flag, 1'b1);
    frame(1'b1, 1'b0);
    chk("R3 second of new chain", async_flag, 1'b1);
    frame(1'b1, 1'b0);
    chk("R3 lock after fresh chain", async_flag, 1'b0);
  endtask

  task automatic t_r4_loss(input logic [1:0] code, input int n);
    acquire(code);
    chk("R4 locked before misses", async_flag, 1'b0);
    for (int k = 1; k <= n; k++) begin
      frame(1'b0, 1'b0);
      chk("R6 strobe on miss frame", frame_start, 1'b1);
      chk($sformatf("R4 code %b miss %0d", code, k), async_flag, (k == n));
    end
  endtask

  task automatic t_r5_clear();
    acquire(2'b11);
    frame(1'b0, 1'b0);
    frame(1'b0, 1'b0);
    chk("R5 two misses", async_flag, 1'b0);
    frame(1'b1, 1'b0);
    frame(1'b0, 1'b0);
    idle(20);
    send(1'b1, 1'b0);   // off-position hit while locked
    idle(FB - 22);
    send(1'b0, 1'b0);
    chk("R5 count cleared by hit", async_flag, 1'b0);
    frame(1'b0, 1'b0);
    chk("R3 R5 off-position hit ignored", async_flag, 1'b1);
  endtask

  task automatic t_r7_code();
    acquire(2'b00);
    frame(1'b0, 1'b0);
    frame(1'b0, 1'b0);
    idle(10);
    front_sel = 2'b11;
    idle(FB - 11);
    send(1'b0, 1'b0);
    chk("R7 old count governs", async_flag, 1'b0);
    frame(1'b0, 1'b0);
    chk("R7 new count governs", async_flag, 1'b1);
  endtask

  task automatic t_r8_stall();
    do_reset(2'b11);
    gap(5);
    send(1'b1, 1'b0);
    idle(30); gap(7); idle(FB - 31);
    send(1'b1, 1'b0);
    chk("R8 two hits across gap", async_flag, 1'b1);
    idle(40); gap(3); idle(FB - 41);
    send(1'b1, 1'b0);
    chk("R8 lock counted in bits", async_flag, 1'b0);
    chk("R8 strobe at lock", frame_start, 1'b1);
    gap(4);
    chk("R8 no strobe in gap", frame_start, 1'b0);
    chk("R8 lock held in gap", async_flag, 1'b0);
  endtask

  task automatic mf_acquire();
    mf_enable = 1'b1;
    frame(1'b1, 1'b1);
    chk("R9 one marker", mf_lock, 1'b0);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b1);  // marker in a non-expected frame
    frame(1'b1, 1'b0);
    chk("R9 still unlocked", mf_lock, 1'b0);
    frame(1'b1, 1'b1);
    chk("R9 master lock", mf_lock, 1'b1);
  endtask

  task automatic t_mf_loss(input logic [1:0] code, input int n);
    acquire(code);
    mf_acquire();
    for (int k = 1; k <= n; k++) begin
      for (int f = 0; f < MF; f++) frame(1'b1, 1'b0);
      chk($sformatf("R10 code %b miss %0d", code, k), mf_lock, (k < n));
    end
  endtask

  task automatic t_r11_clear();
    acquire(2'b11);
    mf_acquire();
    @(negedge clk);
    mf_enable = 1'b0;
    @(posedge clk); #1;
    chk("R11 disable clears", mf_lock, 1'b0);
    mf_enable = 1'b1;
    frame(1'b1, 1'b1);
    for (int f = 1; f < MF; f++) frame(1'b1, 1'b0);
    frame(1'b1, 1'b1);
    chk("R11 relock", mf_lock, 1'b1);
    frame(1'b0, 1'b0);
    frame(1'b0, 1'b0);
    frame(1'b0, 1'b0);
    chk("R11 frame lost", async_flag, 1'b1);
    send(1'b0, 1'b0);
    chk("R11 frame loss clears", mf_lock, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_r1_reset();
    t_r2_acquire();
    t_r3_restart();
    t_r4_loss(2'b11, 3);
    t_r4_loss(2'b10, 5);
    t_r4_loss(2'b01, 7);
    t_r4_loss(2'b00, 9);
    t_r5_clear();
    t_r7_code();
    t_r8_stall();
    t_mf_loss(2'b11, 7);
    t_mf_loss(2'b10, 9);
    t_mf_loss(2'b01, 11);
    t_mf_loss(2'b00, 11);
    t_r11_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule